// File: doc/BRIEF.md
# Interrupt Enable and Clear Controller

This block collects interrupt requests from five sources: external, timer 1, timer 2, asynchronous serial and synchronous serial. A rising edge on a source's request line records a pending flag for that source. The flag stays set until software clears it. Software uses one 16-bit control word for two jobs. The low bits enable individual sources. Writing ones to the matching high bits clears the pending flags of those sources.

A single write can therefore change the enables and acknowledge interrupts in one access. A read returns the enables in the low byte and the pending flags in the high byte. The block drives one combined interrupt line. That line is high whenever at least one source is both pending and enabled. Priority and vectoring belong to the consumer of this line.

Top module: `irq_enable_clear`

## Requirements
- R1: After reset, rd_data reads 0x0000 and irq_out is low. All enables and all pending flags are zero.
- R2: A write updates the enable bits from wr_data[4:0], and they read back at the same positions in rd_data. Bit 0 is external, bit 1 is timer 1, bit 2 is timer 2, bit 3 is asynchronous serial and bit 4 is synchronous serial.
- R3: A rising edge on src_req[i] sets pending flag i. The edge is seen as low at one clock edge and high at the next. From the cycle after that edge, the flag reads at rd_data[8+i]. The source index order is the same as the enable order.
- R4: A pending flag stays set until it is cleared, whatever the source line does. A request held high after a clear does not set the flag again.
- R5: A write with wr_data[8+i] = 1 clears pending flag i. Writing 0 to that bit leaves the flag unchanged.
- R6: A rising edge and a clear of the same source in the same cycle leave that flag set.
- R7: Bits 7..5 and 15..13 of rd_data always read zero.
- R8: irq_out is high exactly when some source is both pending and enabled, as shown by rd_data in the same cycle.
- R9: One write can change enables and clear pending flags together. Both take effect in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 5 | Source request lines; bit order matches the enables |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Write data: enables in [4:0], clear strobes in [12:8] |
| rd_data | output | 16 | Read view: enables in [4:0], pending flags in [12:8] |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The properties assume that src_req is synchronous to clk and low while reset is asserted. The checker keeps its own one-cycle history of the request lines, starting from zero, and that history must match the design's edge detector. The bench changes every input one time unit after a rising edge and holds all request lines low through reset release. Same-cycle rise and clear cases are built by driving both in one cycle.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
   typedef enum int unsigned {
      SRC_EXT  = 0,
      SRC_TMR1 = 1,
      SRC_TMR2 = 2,
      SRC_ASER = 3,
      SRC_SSER = 4
   } irq_src_e;

   localparam int unsigned DEF_NUM_SRC = 5;
   localparam int unsigned DEF_REG_W   = 16;
   localparam int unsigned DEF_CLR_LSB = 8;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
   parameter int unsigned WIDTH = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level_in,
   output logic [WIDTH-1:0] rise_out
);
   logic [WIDTH-1:0] level_q;

   always_ff @(posedge clk) begin
      if (!rst_n) level_q <= '0;
      else        level_q <= level_in;
   end

   assign rise_out = level_in & ~level_q;
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int unsigned WIDTH = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_vec,
   input  logic [WIDTH-1:0] clr_vec,
   output logic [WIDTH-1:0] pend_vec
);
   for (genvar g = 0; g < WIDTH; g++) begin : g_latch
      logic pend_q;
      always_ff @(posedge clk) begin
         if (!rst_n)          pend_q <= 1'b0;
         else if (set_vec[g]) pend_q <= 1'b1;
         else if (clr_vec[g]) pend_q <= 1'b0;
      end
      assign pend_vec[g] = pend_q;
   end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
   parameter int unsigned WIDTH = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_bits,
   output logic [WIDTH-1:0] en_vec
);
   always_ff @(posedge clk) begin
      if (!rst_n)     en_vec <= '0;
      else if (wr_en) en_vec <= wr_bits;
   end
endmodule

// File: rtl/irq_enable_clear.sv
module irq_enable_clear
   import irq_ctl_pkg::*;
#(
   parameter int unsigned NUM_SRC = DEF_NUM_SRC,
   parameter int unsigned REG_W   = DEF_REG_W,
   parameter int unsigned CLR_LSB = DEF_CLR_LSB
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic               wr_en,
   input  logic [REG_W-1:0]   wr_data,
   output logic [REG_W-1:0]   rd_data,
   output logic               irq_out
);
   localparam int unsigned CLR_MSB = CLR_LSB + NUM_SRC - 1;

   if (NUM_SRC < 1 || NUM_SRC > CLR_LSB) begin : g_bad_src
      $error("NUM_SRC must be between 1 and CLR_LSB");
   end
   if (CLR_MSB >= REG_W) begin : g_bad_width
      $error("clear field does not fit in REG_W");
   end

   logic [NUM_SRC-1:0] rise_vec;
   logic [NUM_SRC-1:0] clr_vec;
   logic [NUM_SRC-1:0] pend_vec;
   logic [NUM_SRC-1:0] en_vec;
   logic               unused_wr_bits;

   assign unused_wr_bits = &{1'b0, wr_data};

   irq_edge_detect #(.WIDTH(NUM_SRC)) edge_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_in (src_req),
      .rise_out (rise_vec)
   );

   assign clr_vec = wr_en ? wr_data[CLR_MSB:CLR_LSB] : '0;

   irq_pend_bank #(.WIDTH(NUM_SRC)) pend_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  (rise_vec),
      .clr_vec  (clr_vec),
      .pend_vec (pend_vec)
   );

   irq_enable_reg #(.WIDTH(NUM_SRC)) en_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_bits (wr_data[NUM_SRC-1:0]),
      .en_vec  (en_vec)
   );

   always_comb begin
      rd_data                  = '0;
      rd_data[NUM_SRC-1:0]     = en_vec;
      rd_data[CLR_MSB:CLR_LSB] = pend_vec;
   end

   assign irq_out = |(pend_vec & en_vec);
endmodule

// File: rtl/irq_enable_clear_chk.sv
module irq_enable_clear_chk #(
   parameter int unsigned NUM_SRC = 5,
   parameter int unsigned REG_W   = 16,
   parameter int unsigned CLR_LSB = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_req,
   input logic               wr_en,
   input logic [REG_W-1:0]   wr_data,
   input logic [REG_W-1:0]   rd_data,
   input logic               irq_out
);
   localparam int unsigned CLR_MSB = CLR_LSB + NUM_SRC - 1;

   logic [NUM_SRC-1:0] req_hist;
   logic               unused_chk_bits;

   assign unused_chk_bits = &{1'b0, wr_data};

   always_ff @(posedge clk) begin
      if (!rst_n) req_hist <= '0;
      else        req_hist <= src_req;
   end

   // R7: padding bits stay zero
   p_pad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[CLR_LSB-1:NUM_SRC] == '0 && rd_data[REG_W-1:CLR_MSB+1] == '0);

   // R8: combined output follows the read view
   p_irq_combine_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == |(rd_data[CLR_MSB:CLR_LSB] & rd_data[NUM_SRC-1:0]));

   // R2: enables take the written value
   p_enable_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data[NUM_SRC-1:0] == $past(wr_data[NUM_SRC-1:0]));

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      // R3 and R6: an edge always sets the flag
      p_rise_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (src_req[g] && !req_hist[g]) |=> rd_data[CLR_LSB+g]);

      // R5: a clear strobe without an edge empties the flag
      p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_data[CLR_LSB+g] && !(src_req[g] && !req_hist[g]))
         |=> !rd_data[CLR_LSB+g]);

      // R4: a set flag stays set without a clear strobe
      p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_data[CLR_LSB+g] && !(wr_en && wr_data[CLR_LSB+g]))
         |=> rd_data[CLR_LSB+g]);
   end
endmodule

bind irq_enable_clear irq_enable_clear_chk #(
   .NUM_SRC (NUM_SRC),
   .REG_W   (REG_W),
   .CLR_LSB (CLR_LSB)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .src_req (src_req),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .rd_data (rd_data),
   .irq_out (irq_out)
);

// File: tb/irq_enable_clear_tb_top.sv
module irq_enable_clear_tb_top;
   import irq_ctl_pkg::*;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  src_req = '0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        irq_out;

   int n_checks = 0;
   int n_errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_enable_clear dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_req (src_req),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .irq_out (irq_out)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write_word(input logic [15:0] d);
      wr_en   = 1'b1;
      wr_data = d;
      step();
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   task automatic pulse_src(input int idx);
      src_req[idx] = 1'b1;
      step();
      src_req[idx] = 1'b0;
      step();
   endtask

   task automatic t_reset();
      check("R1 rd_data", rd_data, 16'h0000);
      check("R1 irq_out", {15'd0, irq_out}, 16'h0000);
   endtask

   task automatic t_enable_rw();
      write_word(16'hFFFF);
      check("R2/R7 enables all", rd_data, 16'h001F);
      write_word(16'h00F5);
      check("R2/R7 enables 0x15", rd_data, 16'h0015);
      write_word(16'h0000);
      check("R2 enables cleared", rd_data, 16'h0000);
   endtask

   task automatic t_rise_set();
      logic [4:0] exp_p = '0;
      for (int i = 0; i < 5; i++) begin
         pulse_src(i);
         exp_p[i] = 1'b1;
         check("R3 pending after edge", rd_data, {3'b0, exp_p, 8'h00});
      end
      check("R8 no enables no irq", {15'd0, irq_out}, 16'h0000);
      for (int k = 0; k < 4; k++) step();
      check("R4 pending holds", rd_data, 16'h1F00);
   endtask

   task automatic t_irq_and_zero_clear();
      write_word(16'h0004);
      check("R5 zero clear bits no effect", rd_data, 16'h1F04);
      check("R8 irq with timer2 enabled", {15'd0, irq_out}, 16'h0001);
   endtask

   task automatic t_combined_write();
      write_word(16'h0402);
      check("R9 clear timer2 and enable timer1", rd_data, 16'h1B02);
      check("R8 irq via timer1", {15'd0, irq_out}, 16'h0001);
      write_word(16'h0200);
      check("R5 clear timer1", rd_data, 16'h1900);
      check("R8 irq low after clear", {15'd0, irq_out}, 16'h0000);
      write_word(16'h1900);
      check("R5 clear rest", rd_data, 16'h0000);
   endtask

   task automatic t_level_held();
      src_req[SRC_EXT] = 1'b1;
      step();
      check("R3 ext set", rd_data, 16'h0100);
      write_word(16'h0100);
      check("R4 cleared while high", rd_data, 16'h0000);
      step();
      step();
      check("R4 held level does not reset", rd_data, 16'h0000);
      src_req[SRC_EXT] = 1'b0;
      step();
      check("R4 falling edge ignored", rd_data, 16'h0000);
   endtask

   task automatic t_set_wins();
      src_req[SRC_ASER] = 1'b1;
      wr_en   = 1'b1;
      wr_data = 16'h0800;
      step();
      wr_en   = 1'b0;
      wr_data = '0;
      check("R6 set wins from clear state", rd_data, 16'h0800);
      src_req[SRC_ASER] = 1'b0;
      step();
      src_req[SRC_ASER] = 1'b1;
      wr_en   = 1'b1;
      wr_data = 16'h0808;
      step();
      wr_en   = 1'b0;
      wr_data = '0;
      src_req[SRC_ASER] = 1'b0;
      check("R6 set wins from set state", rd_data, 16'h0808);
      check("R8 irq async", {15'd0, irq_out}, 16'h0001);
      write_word(16'h1F00);
      check("R9 clear all disable all", rd_data, 16'h0000);
   endtask

   initial begin
      step();
      step();
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_enable_rw();
      t_rise_set();
      t_irq_and_zero_clear();
      t_combined_write();
      t_level_held();
      t_set_wins();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule